// File: doc/BRIEF.md
# Network Controller Command/Status Unit

This block is the control point that a host CPU uses to steer the command engine and the receive engine of an Ethernet controller. The host writes a command word carrying a 3-bit command-unit opcode, a 3-bit receive-unit opcode, an interrupt mask bit and a software-interrupt request. The block advances two small state machines and reports their states. It also captures configuration values (the command base, the receive base, the counter dump address and the header data size) and pulses a dump request toward the statistics logic.

Single-cycle event pulses arrive from the datapath: command done (with its interrupt flag), frame received, end of command list, command suspend point, receive suspend point, out of receive buffers and management-interface cycle done. These pulses, together with state transitions, set six interrupt cause bits. The host clears a cause bit by writing a one to it. A single interrupt line is raised while any cause bit is pending and the mask is clear. A selective reset returns both engines to idle and leaves the configuration values as they are.

Top module: `netctl_cmd_status`

## Requirements
- R1: After reset both state outputs read Idle (00), all cause bits, the mask, irq, both dump pulses and all four configuration outputs are zero.
- R2: Command-unit state encoding is Idle 00, Suspended 01, Active 10. A write with command opcode 001 (start) moves the unit to Active from Idle or Suspended. Opcode 010 (resume) moves it to Active only from Suspended. Opcodes 000 and 011 change nothing. An accepted command takes priority over events in the same cycle.
- R3: While the command unit is Active, an end-of-list pulse moves it to Idle and a command-suspend pulse moves it to Suspended. End-of-list wins when both arrive together. Neither pulse has any effect outside Active.
- R4: Receive-unit state encoding is Idle 00, Suspended 01, No Resources 10, Ready 11. Receive opcode 001 moves the unit to Ready from any state, 100 forces Idle from any state, 010 moves Suspended to Ready, and 111 moves No Resources to Ready. Opcodes 000 and 011, and 010 or 111 in any other state, change nothing. An accepted receive command takes priority over events.
- R5: In Ready, an out-of-buffers pulse moves the receive unit to No Resources and a receive-suspend pulse moves it to Suspended. Out-of-buffers wins when both arrive together.
- R6: Cause bit 0 sets on a command-done pulse with its interrupt flag high. Bit 1 sets on a frame-received pulse. Bit 4 sets on a management-cycle-done pulse. Bit 5 sets on a command write with the software-interrupt bit high.
- R7: Cause bit 2 sets when the command unit goes from Active to Idle. Cause bit 3 sets when the receive unit leaves Ready for any other state.
- R8: An acknowledge write clears every cause bit whose acknowledge bit is 1 and leaves the others. A cause that sets in the same cycle as its acknowledge stays set.
- R9: The mask follows the mask bit of every command write. irq is high exactly when a cause bit is pending and the mask is clear. Cause bits keep setting while masked.
- R10: A selective reset pulse puts both units in Idle on the next edge and takes priority over commands and events. It may set bits 2 and 3 per R7, and it leaves all configuration outputs unchanged.
- R11: Command opcode 100 loads cmd_data into dump_addr and 110 loads cu_base. Receive opcode 101 loads hdr_size and 110 loads ru_base. dump_req pulses for one cycle after command opcode 101 or 111, and dump_clr pulses only after 111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_cu_op | input | 3 | Command-unit opcode |
| cmd_ru_op | input | 3 | Receive-unit opcode |
| cmd_mask | input | 1 | Interrupt mask bit of the command word |
| cmd_swi | input | 1 | Software interrupt request bit |
| cmd_data | input | AW | Value for configuration loads |
| ack_wr | input | 1 | Acknowledge write strobe |
| ack_bits | input | 6 | Write-one-to-clear acknowledge bits |
| sel_reset | input | 1 | Selective reset pulse |
| ev_cmd_done | input | 1 | Command finished pulse |
| ev_cmd_irq | input | 1 | Interrupt flag of the finished command |
| ev_frame | input | 1 | Frame or header received pulse |
| ev_list_end | input | 1 | End of command list pulse |
| ev_cu_susp | input | 1 | Command suspend point pulse |
| ev_rx_susp | input | 1 | Receive suspend point pulse |
| ev_no_buf | input | 1 | Out of receive buffers pulse |
| ev_mdi_done | input | 1 | Management cycle done pulse |
| cu_state | output | 2 | Command-unit state |
| ru_state | output | 2 | Receive-unit state |
| cause | output | 6 | Pending interrupt cause bits |
| mask | output | 1 | Current interrupt mask |
| irq | output | 1 | Interrupt request line |
| cu_base | output | AW | Command base value |
| ru_base | output | AW | Receive base value |
| dump_addr | output | AW | Counter dump address |
| hdr_size | output | AW | Header data size |
| dump_req | output | 1 | Statistics dump request pulse |
| dump_clr | output | 1 | Dump-and-clear qualifier pulse |

## Verification
The hardest situations to reach are those in which a host write and datapath pulses land in the same cycle. Examples are a start command on an Active unit racing an end-of-list pulse, or an acknowledge racing a new set of the same cause bit. No Resources is reached only after a start followed by an out-of-buffers pulse. The stimulus combines directed chains that walk each unit through every state with thousands of random cycles. In those cycles writes, acknowledges, events and selective resets overlap freely, and every output is compared each cycle against a bench model built from the requirements.

// File: rtl/netctl_cmd_status.sv
module netctl_cmd_status #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wr,
  input  logic [2:0]    cmd_cu_op,
  input  logic [2:0]    cmd_ru_op,
  input  logic          cmd_mask,
  input  logic          cmd_swi,
  input  logic [AW-1:0] cmd_data,
  input  logic          ack_wr,
  input  logic [5:0]    ack_bits,
  input  logic          sel_reset,
  input  logic          ev_cmd_done,
  input  logic          ev_cmd_irq,
  input  logic          ev_frame,
  input  logic          ev_list_end,
  input  logic          ev_cu_susp,
  input  logic          ev_rx_susp,
  input  logic          ev_no_buf,
  input  logic          ev_mdi_done,
  output logic [1:0]    cu_state,
  output logic [1:0]    ru_state,
  output logic [5:0]    cause,
  output logic          mask,
  output logic          irq,
  output logic [AW-1:0] cu_base,
  output logic [AW-1:0] ru_base,
  output logic [AW-1:0] dump_addr,
  output logic [AW-1:0] hdr_size,
  output logic          dump_req,
  output logic          dump_clr
);
  localparam logic [1:0] CU_IDLE = 2'd0, CU_SUSP = 2'd1, CU_ACT = 2'd2;
  localparam logic [1:0] RU_IDLE = 2'd0, RU_SUSP = 2'd1, RU_NORES = 2'd2, RU_READY = 2'd3;

  logic       cu_wr_start, cu_wr_resume, ru_wr_start, ru_wr_resume, ru_wr_abort, ru_wr_rbd;
  logic [1:0] cu_nx, ru_nx;
  logic [5:0] cause_set, cause_clr;

  assign cu_wr_start  = cmd_wr && cmd_cu_op == 3'b001;
  assign cu_wr_resume = cmd_wr && cmd_cu_op == 3'b010;
  assign ru_wr_start  = cmd_wr && cmd_ru_op == 3'b001;
  assign ru_wr_resume = cmd_wr && cmd_ru_op == 3'b010;
  assign ru_wr_abort  = cmd_wr && cmd_ru_op == 3'b100;
  assign ru_wr_rbd    = cmd_wr && cmd_ru_op == 3'b111;

  always_comb begin
    cu_nx = cu_state;
    if (sel_reset)                                  cu_nx = CU_IDLE;
    else if (cu_wr_start && cu_state != CU_ACT)     cu_nx = CU_ACT;
    else if (cu_wr_resume && cu_state == CU_SUSP)   cu_nx = CU_ACT;
    else if (cu_state == CU_ACT && ev_list_end)     cu_nx = CU_IDLE;
    else if (cu_state == CU_ACT && ev_cu_susp)      cu_nx = CU_SUSP;
  end

  always_comb begin
    ru_nx = ru_state;
    if (sel_reset)                                  ru_nx = RU_IDLE;
    else if (ru_wr_start)                           ru_nx = RU_READY;
    else if (ru_wr_abort)                           ru_nx = RU_IDLE;
    else if (ru_wr_resume && ru_state == RU_SUSP)   ru_nx = RU_READY;
    else if (ru_wr_rbd && ru_state == RU_NORES)     ru_nx = RU_READY;
    else if (ru_state == RU_READY && ev_no_buf)     ru_nx = RU_NORES;
    else if (ru_state == RU_READY && ev_rx_susp)    ru_nx = RU_SUSP;
  end

  assign cause_set = {cmd_wr && cmd_swi,
                      ev_mdi_done,
                      ru_state == RU_READY && ru_nx != RU_READY,
                      cu_state == CU_ACT && cu_nx == CU_IDLE,
                      ev_frame,
                      ev_cmd_done && ev_cmd_irq};
  assign cause_clr = ack_wr ? ack_bits : 6'd0;
  assign irq = (|cause) && !mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cu_state  <= CU_IDLE;
      ru_state  <= RU_IDLE;
      cause     <= '0;
      mask      <= 1'b0;
      cu_base   <= '0;
      ru_base   <= '0;
      dump_addr <= '0;
      hdr_size  <= '0;
      dump_req  <= 1'b0;
      dump_clr  <= 1'b0;
    end else begin
      cu_state <= cu_nx;
      ru_state <= ru_nx;
      cause    <= (cause & ~cause_clr) | cause_set;
      if (cmd_wr) mask <= cmd_mask;
      if (cmd_wr && cmd_cu_op == 3'b100) dump_addr <= cmd_data;
      if (cmd_wr && cmd_cu_op == 3'b110) cu_base   <= cmd_data;
      if (cmd_wr && cmd_ru_op == 3'b101) hdr_size  <= cmd_data;
      if (cmd_wr && cmd_ru_op == 3'b110) ru_base   <= cmd_data;
      dump_req <= cmd_wr && (cmd_cu_op == 3'b101 || cmd_cu_op == 3'b111);
      dump_clr <= cmd_wr && cmd_cu_op == 3'b111;
    end
  end

  assert_cu_encoding_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cu_state != 2'b11) else $error("cu_state illegal");

  assert_cu_idle_to_act_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cu_state) == CU_IDLE && cu_state == CU_ACT) |-> $past(cu_wr_start))
    else $error("cu left idle without start");

  assert_ru_idle_to_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ru_state) == RU_IDLE && ru_state == RU_READY) |-> $past(ru_wr_start))
    else $error("ru left idle without start");

  assert_cna_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cause[2]) |-> ($past(cu_state) == CU_ACT && cu_state == CU_IDLE))
    else $error("cna without active-to-idle");

  assert_rnr_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cause[3]) |-> ($past(ru_state) == RU_READY && ru_state != RU_READY))
    else $error("rnr without leaving ready");

  assert_masked_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask && ev_mdi_done) |=> cause[4]) else $error("cause lost while masked");

  assert_selreset_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sel_reset |=> (cu_state == CU_IDLE && ru_state == RU_IDLE))
    else $error("selective reset missed");

  assert_selreset_cfg_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_reset && !cmd_wr) |=> ($stable(cu_base) && $stable(ru_base) && $stable(hdr_size)))
    else $error("selective reset touched config");
endmodule

// File: tb/tb_netctl_cmd_status.sv
module tb_netctl_cmd_status;
  localparam int AW = 32;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_wr, cmd_mask, cmd_swi, ack_wr, sel_reset;
  logic [2:0] cmd_cu_op, cmd_ru_op;
  logic [AW-1:0] cmd_data;
  logic [5:0] ack_bits;
  logic ev_cmd_done, ev_cmd_irq, ev_frame, ev_list_end, ev_cu_susp, ev_rx_susp, ev_no_buf, ev_mdi_done;
  logic [1:0] cu_state, ru_state;
  logic [5:0] cause;
  logic mask, irq, dump_req, dump_clr;
  logic [AW-1:0] cu_base, ru_base, dump_addr, hdr_size;

  logic [1:0] m_cu, m_ru;
  logic [5:0] m_cause;
  logic m_mask, m_dreq, m_dclr;
  logic [AW-1:0] m_cub, m_rub, m_dad, m_hdr;
  int checks = 0, errors = 0;
  string phase = "reset";

  always #4 clk = ~clk;

  netctl_cmd_status #(.AW(AW)) dut (.*);

  task automatic chk(string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s [%s] actual=%0h expected=%0h", tag, phase, act, exp);
    end
  endtask

  task automatic compare();
    chk("R2/R3 cu_state", cu_state, m_cu);
    chk("R4/R5 ru_state", ru_state, m_ru);
    chk("R6/R7/R8 cause", cause, m_cause);
    chk("R9 mask", mask, m_mask);
    chk("R9 irq", irq, (|m_cause) && !m_mask);
    chk("R11 cu_base", cu_base, m_cub);
    chk("R11 ru_base", ru_base, m_rub);
    chk("R11 dump_addr", dump_addr, m_dad);
    chk("R11 hdr_size", hdr_size, m_hdr);
    chk("R11 dump_req", dump_req, m_dreq);
    chk("R11 dump_clr", dump_clr, m_dclr);
  endtask

  task automatic idle_in();
    cmd_wr = 0; cmd_cu_op = 0; cmd_ru_op = 0; cmd_mask = 0; cmd_swi = 0; cmd_data = 0;
    ack_wr = 0; ack_bits = 0; sel_reset = 0;
    ev_cmd_done = 0; ev_cmd_irq = 0; ev_frame = 0; ev_list_end = 0;
    ev_cu_susp = 0; ev_rx_susp = 0; ev_no_buf = 0; ev_mdi_done = 0;
  endtask

  function automatic logic [1:0] cu_next();
    if (sel_reset) return 2'd0;
    if (cmd_wr && cmd_cu_op == 3'd1 && m_cu != 2'd2) return 2'd2;
    if (cmd_wr && cmd_cu_op == 3'd2 && m_cu == 2'd1) return 2'd2;
    if (m_cu == 2'd2 && ev_list_end) return 2'd0;
    if (m_cu == 2'd2 && ev_cu_susp) return 2'd1;
    return m_cu;
  endfunction

  function automatic logic [1:0] ru_next();
    if (sel_reset) return 2'd0;
    if (cmd_wr && cmd_ru_op == 3'd1) return 2'd3;
    if (cmd_wr && cmd_ru_op == 3'd4) return 2'd0;
    if (cmd_wr && cmd_ru_op == 3'd2 && m_ru == 2'd1) return 2'd3;
    if (cmd_wr && cmd_ru_op == 3'd7 && m_ru == 2'd2) return 2'd3;
    if (m_ru == 2'd3 && ev_no_buf) return 2'd2;
    if (m_ru == 2'd3 && ev_rx_susp) return 2'd1;
    return m_ru;
  endfunction

  task automatic step();
    logic [1:0] ncu, nru;
    logic [5:0] set;
    ncu = cu_next();
    nru = ru_next();
    set = {cmd_wr && cmd_swi, ev_mdi_done, m_ru == 2'd3 && nru != 2'd3,
           m_cu == 2'd2 && ncu == 2'd0, ev_frame, ev_cmd_done && ev_cmd_irq};
    m_cause = (m_cause & ~(ack_wr ? ack_bits : 6'd0)) | set;
    if (cmd_wr) m_mask = cmd_mask;
    if (cmd_wr && cmd_cu_op == 3'd4) m_dad = cmd_data;
    if (cmd_wr && cmd_cu_op == 3'd6) m_cub = cmd_data;
    if (cmd_wr && cmd_ru_op == 3'd5) m_hdr = cmd_data;
    if (cmd_wr && cmd_ru_op == 3'd6) m_rub = cmd_data;
    m_dreq = cmd_wr && (cmd_cu_op == 3'd5 || cmd_cu_op == 3'd7);
    m_dclr = cmd_wr && cmd_cu_op == 3'd7;
    m_cu = ncu;
    m_ru = nru;
    @(negedge clk);
    compare();
    idle_in();
  endtask

  task automatic wr(logic [2:0] cu, logic [2:0] ru, logic mk, logic [AW-1:0] d);
    cmd_wr = 1; cmd_cu_op = cu; cmd_ru_op = ru; cmd_mask = mk; cmd_data = d;
  endtask

  initial begin
    idle_in();
    m_cu = 0; m_ru = 0; m_cause = 0; m_mask = 0; m_dreq = 0; m_dclr = 0;
    m_cub = 0; m_rub = 0; m_dad = 0; m_hdr = 0;
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    phase = "R1 reset state";
    compare();

    phase = "R2 resume from idle ignored";
    wr(3'd2, 3'd3, 0, 0); step();
    phase = "R2 start";            wr(3'd1, 0, 0, 0); step();
    phase = "R3 suspend";          ev_cu_susp = 1; step();
    phase = "R2 resume";           wr(3'd2, 0, 0, 0); step();
    phase = "R3 R7 list end wins"; ev_list_end = 1; ev_cu_susp = 1; step();
    phase = "R3 event ignored in idle"; ev_cu_susp = 1; step();

    phase = "R4 ru start";         wr(0, 3'd1, 0, 0); step();
    phase = "R5 R7 no_buf wins";   ev_no_buf = 1; ev_rx_susp = 1; step();
    phase = "R4 resume ignored in nores"; wr(0, 3'd2, 0, 0); step();
    phase = "R4 rbd resume";       wr(0, 3'd7, 0, 0); step();
    phase = "R5 rx suspend";       ev_rx_susp = 1; step();
    phase = "R4 resume";           wr(0, 3'd2, 0, 0); step();
    phase = "R4 abort";            wr(0, 3'd4, 0, 0); step();

    phase = "R8 ack all";          ack_wr = 1; ack_bits = 6'h3f; step();
    phase = "R9 masked latch";     wr(0, 0, 1, 0); cmd_swi = 1; step();
    phase = "R9 masked events";    ev_mdi_done = 1; ev_frame = 1; step();
    phase = "R6 cx flag low";      ev_cmd_done = 1; step();
    phase = "R6 cx flag high";     ev_cmd_done = 1; ev_cmd_irq = 1; step();
    phase = "R9 unmask";           wr(0, 0, 0, 0); step();
    phase = "R8 ack racing set";   ack_wr = 1; ack_bits = 6'h13; ev_mdi_done = 1; step();

    phase = "R11 loads";           wr(3'd6, 3'd6, 0, 32'hCAFE0001); step();
    wr(3'd4, 3'd5, 0, 32'h0BAD0002); step();
    phase = "R11 dump";            wr(3'd5, 0, 0, 0); step();
    phase = "R11 dump clear";      wr(3'd7, 0, 0, 0); step();
    phase = "R11 pulse ends";      step();
    phase = "R10 setup";           wr(3'd1, 3'd1, 0, 0); step();
    phase = "R10 selective reset"; sel_reset = 1; wr(3'd1, 3'd1, 0, 0); step();
    phase = "R10 after";           step();

    phase = "random";
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(3) == 0) begin
        wr(3'($urandom_range(7)), 3'($urandom_range(7)), 1'($urandom_range(3) == 0), $urandom());
        cmd_swi = ($urandom_range(7) == 0);
      end
      if ($urandom_range(5) == 0) begin ack_wr = 1; ack_bits = 6'($urandom()); end
      sel_reset   = ($urandom_range(63) == 0);
      ev_cmd_done = ($urandom_range(7) == 0);
      ev_cmd_irq  = $urandom_range(1);
      ev_frame    = ($urandom_range(7) == 0);
      ev_list_end = ($urandom_range(7) == 0);
      ev_cu_susp  = ($urandom_range(7) == 0);
      ev_rx_susp  = ($urandom_range(7) == 0);
      ev_no_buf   = ($urandom_range(7) == 0);
      ev_mdi_done = ($urandom_range(9) == 0);
      step();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog [%s] actual=timeout expected=done", phase);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule